// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block owns two jobs for an asynchronous DRAM: bringing the array up after power-on, and keeping its contents alive afterwards. After reset it stays quiet for a programmable power-up wait. It then asks the access controller for the bus and runs a burst of warm-up refresh cycles. Once the last warm-up cycle has finished its RAS precharge, the block raises `initDone`. From that point the access controller may serve normal traffic.

In normal operation an interval counter marks one refresh as due every `REF_INTERVAL_CYC` clocks, so that every row is refreshed within the retention period. Each due refresh is recorded in a small saturating pending counter. The block raises `busReq` and waits for `busGrant`. It then drives the strobes itself and issues every pending refresh back to back before it releases the bus. Each refresh is a CAS-before-RAS cycle with WE held high, so no row address is needed and the cycle is never taken as a test-mode entry. All durations are parameters in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busReq`, `driveEn` and `initDone` are 0 and `rasN`, `casN`, `weN` are 1.
- R2: `busReq` stays 0 during the power-up wait and first rises exactly `PWRUP_CYC`+1 clock edges after reset is released.
- R3: Exactly `WARMUP_CNT` refresh cycles occur before `initDone` rises, all within the first bus ownership. `initDone` rises in the cycle after the last one's precharge ends, and it never falls again until reset.
- R4: `driveEn` is 1 only while `busReq` and `busGrant` are both 1. While the grant is withheld, `busReq` stays high and the strobes are not driven.
- R5: In each refresh, `casN` is low for exactly `CAS_LEAD_CYC` cycles before `rasN` falls, stays low throughout the RAS low pulse, and rises together with `rasN`.
- R6: `rasN` is low for exactly `RAS_LOW_CYC` cycles per refresh. Between two refreshes in one ownership, RAS and CAS are both high for exactly `RAS_PRE_CYC` cycles before CAS falls again. The bus is released only after that precharge.
- R7: `weN` is 1 at every CAS and RAS falling edge and at all other times.
- R8: After `initDone`, a refresh falls due every `REF_INTERVAL_CYC` cycles, and the first request comes `REF_INTERVAL_CYC`+1 edges after `initDone` rises. While the grant is withheld, the interval counter keeps running. Refreshes that fall due in the meantime are all issued back to back in one ownership.
- R9: The pending count saturates at 2^`PEND_W`-1: however long the grant is withheld, one ownership issues at most that many refreshes.
- R10: After a grant, CAS stays high for exactly `CAS_PRE_CYC` driven cycles before its first fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busGrant | input | 1 | Access controller hands the DRAM strobes to this block |
| busReq | output | 1 | Request for the DRAM strobes, held until the last refresh precharge ends |
| driveEn | output | 1 | This block is driving `rasN`/`casN`/`weN` onto the DRAM |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low (always high here) |
| initDone | output | 1 | Power-up wait and warm-up refreshes are complete |

## Verification
The assertions assume that the access controller, once it has raised `busGrant`, holds it until `busReq` falls. They also assume it grants only when its own strobes are idle. The stimulus follows both rules: it raises the grant only while `busReq` is high and lowers it at the first sample where `busReq` is low. The grant delays in the table are chosen so that no interval tick lands in the middle of a refresh burst. Because of this, the expected burst lengths of 1, 2, 3 and a saturated 3 follow directly from the delay.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_REQ,
    ST_ARM,
    ST_CASLEAD,
    ST_RASLOW,
    ST_PRE
  } schedState_t;

  typedef enum logic [1:0] {
    PH_ARM,
    PH_CASLEAD,
    PH_RASLOW,
    PH_PRE
  } phaseSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      phaseLoad;
    phaseSel_t phaseSel;
    logic      warmInc;
    logic      pendDec;
    logic      initSet;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pwrupDone;
    logic phaseDone;
    logic pendNz;
    logic warmLast;
    logic initDone;
  } dpStatus_t;

endpackage

// File: rtl/refsch_datapath.sv
module refsch_datapath
  import refsch_pkg::*;
#(
  parameter int PWRUP_CYC        = 40000,
  parameter int WARMUP_CNT       = 8,
  parameter int REF_INTERVAL_CYC = 3120,
  parameter int CAS_PRE_CYC      = 2,
  parameter int CAS_LEAD_CYC     = 2,
  parameter int RAS_LOW_CYC      = 12,
  parameter int RAS_PRE_CYC      = 8,
  parameter int PEND_W           = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t stb,
  output dpStatus_t   sts
);

  localparam int PWR_W   = $clog2(PWRUP_CYC + 1);
  localparam int INT_W   = $clog2(REF_INTERVAL_CYC + 1);
  localparam int WARM_W  = $clog2(WARMUP_CNT + 1);
  localparam int PH_MAX1 = (CAS_PRE_CYC > CAS_LEAD_CYC) ? CAS_PRE_CYC : CAS_LEAD_CYC;
  localparam int PH_MAX2 = (RAS_LOW_CYC > RAS_PRE_CYC) ? RAS_LOW_CYC : RAS_PRE_CYC;
  localparam int PH_MAX  = (PH_MAX1 > PH_MAX2) ? PH_MAX1 : PH_MAX2;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  // power-up wait
  logic [PWR_W-1:0] pwrCnt;
  logic             pwrupDone;
  assign pwrupDone = (pwrCnt == PWR_W'(PWRUP_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pwrCnt <= '0;
    else if (!pwrupDone) pwrCnt <= pwrCnt + PWR_W'(1);
  end

  // phase timer
  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] phaseLenM1;

  always_comb begin
    unique case (stb.phaseSel)
      PH_ARM:     phaseLenM1 = PH_W'(CAS_PRE_CYC - 1);
      PH_CASLEAD: phaseLenM1 = PH_W'(CAS_LEAD_CYC - 1);
      PH_RASLOW:  phaseLenM1 = PH_W'(RAS_LOW_CYC - 1);
      default:    phaseLenM1 = PH_W'(RAS_PRE_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (stb.phaseLoad)    phaseCnt <= phaseLenM1;
    else if (phaseCnt != '0)   phaseCnt <= phaseCnt - PH_W'(1);
  end

  // warm-up counter and init flag
  logic [WARM_W-1:0] warmCnt;
  logic              initDoneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt   <= '0;
      initDoneQ <= 1'b0;
    end else begin
      if (stb.warmInc) warmCnt <= warmCnt + WARM_W'(1);
      if (stb.initSet) initDoneQ <= 1'b1;
    end
  end

  // refresh interval counter, runs regardless of bus ownership
  logic [INT_W-1:0] intCnt;
  logic             tick;
  assign tick = initDoneQ && (intCnt == INT_W'(REF_INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           intCnt <= '0;
    else if (!initDoneQ) intCnt <= '0;
    else if (tick)       intCnt <= '0;
    else                 intCnt <= intCnt + INT_W'(1);
  end

  // pending refreshes, saturating
  logic [PEND_W-1:0] pendCnt;
  logic              incEff;
  assign incEff = tick && ((pendCnt != PEND_MAX) || stb.pendDec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        pendCnt <= '0;
    else if (incEff && !stb.pendDec)  pendCnt <= pendCnt + PEND_W'(1);
    else if (!incEff && stb.pendDec)  pendCnt <= pendCnt - PEND_W'(1);
  end

  always_comb begin
    sts.pwrupDone = pwrupDone;
    sts.phaseDone = (phaseCnt == '0);
    sts.pendNz    = (pendCnt != '0);
    sts.warmLast  = (warmCnt == WARM_W'(WARMUP_CNT - 1));
    sts.initDone  = initDoneQ;
  end

  // R9: a saturated queue never wraps to empty on a tick
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt == PEND_MAX && tick && !stb.pendDec) |=> (pendCnt == PEND_MAX))
    else $error("pending counter wrapped");

  // R8: control consumes a pending refresh only when one is queued
  a_r8_dec_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    stb.pendDec |-> (pendCnt != '0))
    else $error("pending decremented while empty");

  // R3: no warm-up cycles are counted once init is complete
  a_r3_no_late_warmup: assert property (@(posedge clk) disable iff (!rstN)
    stb.warmInc |-> !initDoneQ)
    else $error("warm-up counted after init");

endmodule

// File: rtl/refsch_ctrl.sv
module refsch_ctrl
  import refsch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busGrant,
  input  dpStatus_t   sts,
  output ctrlStrobe_t stb,
  output logic        busReq,
  output logic        driveEn,
  output logic        rasN,
  output logic        casN,
  output logic        weN
);

  schedState_t state, nextState;

  always_comb begin
    nextState    = state;
    stb          = '0;
    stb.phaseSel = PH_ARM;
    unique case (state)
      ST_PWRUP: if (sts.pwrupDone) nextState = ST_REQ;
      ST_IDLE:  if (sts.pendNz)    nextState = ST_REQ;
      ST_REQ: begin
        if (busGrant) begin
          nextState     = ST_ARM;
          stb.phaseLoad = 1'b1;
          stb.phaseSel  = PH_ARM;
        end
      end
      ST_ARM: begin
        if (sts.phaseDone) begin
          nextState     = ST_CASLEAD;
          stb.phaseLoad = 1'b1;
          stb.phaseSel  = PH_CASLEAD;
          stb.pendDec   = sts.initDone;
        end
      end
      ST_CASLEAD: begin
        if (sts.phaseDone) begin
          nextState     = ST_RASLOW;
          stb.phaseLoad = 1'b1;
          stb.phaseSel  = PH_RASLOW;
        end
      end
      ST_RASLOW: begin
        if (sts.phaseDone) begin
          nextState     = ST_PRE;
          stb.phaseLoad = 1'b1;
          stb.phaseSel  = PH_PRE;
        end
      end
      ST_PRE: begin
        if (sts.phaseDone) begin
          if (!sts.initDone) begin
            stb.warmInc = 1'b1;
            if (sts.warmLast) begin
              stb.initSet = 1'b1;
              nextState   = ST_IDLE;
            end else begin
              nextState     = ST_CASLEAD;
              stb.phaseLoad = 1'b1;
              stb.phaseSel  = PH_CASLEAD;
            end
          end else if (sts.pendNz) begin
            nextState     = ST_CASLEAD;
            stb.phaseLoad = 1'b1;
            stb.phaseSel  = PH_CASLEAD;
            stb.pendDec   = 1'b1;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // pins registered from the next state so they change cleanly on the edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PWRUP;
      busReq  <= 1'b0;
      driveEn <= 1'b0;
      rasN    <= 1'b1;
      casN    <= 1'b1;
      weN     <= 1'b1;
    end else begin
      state   <= nextState;
      busReq  <= nextState inside {ST_REQ, ST_ARM, ST_CASLEAD, ST_RASLOW, ST_PRE};
      driveEn <= nextState inside {ST_ARM, ST_CASLEAD, ST_RASLOW, ST_PRE};
      rasN    <= (nextState != ST_RASLOW);
      casN    <= !(nextState inside {ST_CASLEAD, ST_RASLOW});
      weN     <= 1'b1;
    end
  end

  // R4: strobes only driven while granted
  a_r4_drive_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> busGrant)
    else $error("driving without grant");

  // R4: driving implies an open request
  a_r4_drive_within_req: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> busReq)
    else $error("driving without request");

  // R5: RAS low only inside CAS low
  a_r5_ras_inside_cas: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !casN)
    else $error("RAS low while CAS high");

  // R5: CAS already low in the cycle before RAS falls
  a_r5_cas_before_ras: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(!casN))
    else $error("RAS fell without CAS lead");

  // R2: no request during the power-up wait
  a_r2_quiet_before_pwrup: assert property (@(posedge clk) disable iff (!rstN)
    !sts.pwrupDone |-> !busReq)
    else $error("request during power-up wait");

  // R3: init flag is sticky
  a_r3_init_sticky: assert property (@(posedge clk) disable iff (!rstN)
    sts.initDone |=> sts.initDone)
    else $error("init flag dropped");

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import refsch_pkg::*;
#(
  parameter int PWRUP_CYC        = 40000,
  parameter int WARMUP_CNT       = 8,
  parameter int REF_INTERVAL_CYC = 3120,
  parameter int CAS_PRE_CYC      = 2,
  parameter int CAS_LEAD_CYC     = 2,
  parameter int RAS_LOW_CYC      = 12,
  parameter int RAS_PRE_CYC      = 8,
  parameter int PEND_W           = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busGrant,
  output logic busReq,
  output logic driveEn,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic initDone
);

  ctrlStrobe_t stb;
  dpStatus_t   sts;

  refsch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busGrant (busGrant),
    .sts      (sts),
    .stb      (stb),
    .busReq   (busReq),
    .driveEn  (driveEn),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN)
  );

  refsch_datapath #(
    .PWRUP_CYC        (PWRUP_CYC),
    .WARMUP_CNT       (WARMUP_CNT),
    .REF_INTERVAL_CYC (REF_INTERVAL_CYC),
    .CAS_PRE_CYC      (CAS_PRE_CYC),
    .CAS_LEAD_CYC     (CAS_LEAD_CYC),
    .RAS_LOW_CYC      (RAS_LOW_CYC),
    .RAS_PRE_CYC      (RAS_PRE_CYC),
    .PEND_W           (PEND_W)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .sts  (sts)
  );

  assign initDone = sts.initDone;

endmodule

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/100ps
module dram_refresh_sched_test;

  localparam int PWRUP    = 50;
  localparam int WARM     = 8;
  localparam int INTERVAL = 100;
  localparam int CAS_PRE  = 2;
  localparam int CAS_LEAD = 2;
  localparam int RAS_LOW  = 12;
  localparam int RAS_PRE  = 8;
  localparam int PEND_W   = 2;
  localparam int PEND_MAX = (1 << PEND_W) - 1;

  localparam int NVEC = 5;
  localparam int GRANT_DLY [NVEC] = '{0, 110, 210, 410, 30};
  localparam int EXP_CNT   [NVEC] = '{1, 2, 3, PEND_MAX, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busGrant = 1'b0;
  logic busReq, driveEn, rasN, casN, weN, initDone;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .PWRUP_CYC(PWRUP), .WARMUP_CNT(WARM), .REF_INTERVAL_CYC(INTERVAL),
    .CAS_PRE_CYC(CAS_PRE), .CAS_LEAD_CYC(CAS_LEAD), .RAS_LOW_CYC(RAS_LOW),
    .RAS_PRE_CYC(RAS_PRE), .PEND_W(PEND_W)
  ) uut (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .busReq(busReq),
    .driveEn(driveEn), .rasN(rasN), .casN(casN), .weN(weN), .initDone(initDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkResetState(input string tag);
    check(busReq == 1'b0,   {tag, " busReq"},   int'(busReq), 0);
    check(driveEn == 1'b0,  {tag, " driveEn"},  int'(driveEn), 0);
    check(initDone == 1'b0, {tag, " initDone"}, int'(initDone), 0);
    check(rasN && casN && weN, {tag, " strobes idle"}, int'({rasN, casN, weN}), 7);
  endtask

  // protocol monitor, samples on the falling edge
  int  cyc, casLowRun, rasLowRun, casHighRun, casFalls, ownCount, initCyc;
  bit  firstInOwn, initSeen, reqSeen;
  logic pRas, pCas, pReq, pInit;

  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0; casLowRun = 0; rasLowRun = 0; casHighRun = 0;
      casFalls = 0; ownCount = 0; initCyc = 0;
      firstInOwn = 0; initSeen = 0; reqSeen = 0;
      pRas = 1'b1; pCas = 1'b1; pReq = 1'b0; pInit = 1'b0;
    end else begin
      cyc++;
      if (!weN) check(0, "R7 weN low", 0, 1);
      if (driveEn && !(busGrant && busReq)) check(0, "R4 drive without grant", 1, 0);
      if (busReq && !pReq) begin
        ownCount = 0;
        firstInOwn = 1;
        if (!reqSeen) begin
          reqSeen = 1;
          check(cyc == PWRUP + 1, "R2 first request cycle", cyc, PWRUP + 1);
        end else if (initSeen) begin
          check(((cyc - initCyc) % INTERVAL) == 1, "R8 request spacing",
                (cyc - initCyc) % INTERVAL, 1);
        end
      end
      if (pCas && !casN) begin
        casFalls++;
        ownCount++;
        if (firstInOwn)
          check(casHighRun == CAS_PRE, "R10 CAS precharge after grant", casHighRun, CAS_PRE);
        else
          check(casHighRun == RAS_PRE, "R6 precharge between refreshes", casHighRun, RAS_PRE);
        check(weN == 1'b1, "R7 weN at CAS fall", int'(weN), 1);
        firstInOwn = 0;
      end
      if (pRas && !rasN) begin
        check(casLowRun == CAS_LEAD, "R5 CAS lead before RAS", casLowRun, CAS_LEAD);
        check(weN == 1'b1, "R7 weN at RAS fall", int'(weN), 1);
      end
      if (!pRas && rasN) begin
        check(rasLowRun == RAS_LOW, "R6 RAS low width", rasLowRun, RAS_LOW);
        check(casN == 1'b1, "R5 CAS rises with RAS", int'(casN), 1);
      end
      if (initDone && !pInit) begin
        check(casFalls == WARM, "R3 warm-up count", casFalls, WARM);
        check(rasN && casN, "R3 init after precharge", int'({rasN, casN}), 3);
        initSeen = 1;
        initCyc = cyc;
      end
      if (!initDone && pInit) check(0, "R3 initDone fell", 0, 1);
      casLowRun  = casN ? 0 : casLowRun + 1;
      rasLowRun  = rasN ? 0 : rasLowRun + 1;
      casHighRun = (driveEn && casN) ? casHighRun + 1 : 0;
      pRas = rasN; pCas = casN; pReq = busReq; pInit = initDone;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    busGrant = 1'b0;
    repeat (3) @(negedge clk);
    checkResetState("R1 in reset");
    #1 rstN = 1'b1;
    @(negedge clk);
    checkResetState("R1 after release");

    // warm-up: grant at once
    while (!busReq) @(negedge clk);
    busGrant = 1'b1;
    while (busReq) @(negedge clk);
    busGrant = 1'b0;
    check(ownCount == WARM, "R3 warm-up in one ownership", ownCount, WARM);
    check(initDone == 1'b1, "R3 initDone after warm-up", int'(initDone), 1);

    // table walk: grant delay vs refreshes issued in one ownership
    for (int i = 0; i < NVEC; i++) begin
      while (!busReq) @(negedge clk);
      repeat (GRANT_DLY[i]) @(negedge clk);
      check(busReq && !driveEn, "R4 waiting for grant", int'({busReq, driveEn}), 2);
      busGrant = 1'b1;
      while (busReq) @(negedge clk);
      busGrant = 1'b0;
      if (EXP_CNT[i] == PEND_MAX && GRANT_DLY[i] > PEND_MAX * INTERVAL)
        check(ownCount == EXP_CNT[i], "R9 saturated burst", ownCount, EXP_CNT[i]);
      else
        check(ownCount == EXP_CNT[i], "R8 burst length", ownCount, EXP_CNT[i]);
    end

    // directed: reset while a request is pending
    while (!busReq) @(negedge clk);
    #1 rstN = 1'b0;
    @(negedge clk);
    checkResetState("R1 mid-run reset");
    #1 rstN = 1'b1;
    repeat (PWRUP - 2) @(negedge clk);
    check(busReq == 1'b0, "R2 quiet after re-reset", int'(busReq), 0);
    while (!busReq) @(negedge clk);
    @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule